// File: doc/BRIEF.md
# Bank Activation Timing Guard

This block sits in front of a four-bank mobile DDR memory, on the command path from a controller. Each cycle it looks at the command offered to it, together with a bank and a row address. It answers on `cmd_ok` whether that command may go out in this cycle without breaking the row-opening rules.

The guard remembers which banks hold an open row and which row that is. It keeps countdowns for three rules:

- the wait from opening a row to accessing it;
- the wait between two row openings in the same bank;
- the wait between row openings in any two banks.

Every wait is given as a time in picoseconds and turned into whole clock cycles at elaboration.

A command takes effect only when `cmd_valid` is high and `cmd_ok` is high in the same cycle. The controller is expected to hold back any command that the guard refuses. An access to a bank with no open row is also reported on `proto_err`.

Top module: `bank_act_guard`

## Requirements
- R1: After reset every bank is closed (`bank_open` = 0) and all countdowns are zero, so an ACTIVE to any bank is accepted in the first cycle after reset.
- R2: Command codes are NOP=0, ACTIVE=1, READ=2, WRITE=3, PRECHARGE=4. Codes 5 to 7 behave like NOP. A NOP is always allowed (`cmd_ok`=1) and changes no state.
- R3: An accepted ACTIVE opens the addressed bank and stores its row. `open_row` shows the stored row of the bank currently on `cmd_bank`.
- R4: A READ or WRITE to a closed bank gets `cmd_ok`=0, and `proto_err`=1 while `cmd_valid` is high.
- R5: A READ or WRITE to an open bank is allowed only once at least `ceil(TRCD_PS/CLK_PS)` cycles have passed since the ACTIVE to that bank was accepted.
- R6: An ACTIVE to a bank is allowed only once at least `ceil(TRC_PS/CLK_PS)` cycles have passed since the previous accepted ACTIVE to the same bank. This holds even if the bank was precharged in between.
- R7: An ACTIVE is allowed only once at least `ceil(TRRD_PS/CLK_PS)` cycles have passed since the last accepted ACTIVE to any bank.
- R8: An ACTIVE to a bank that is already open gets `cmd_ok`=0 until a PRECHARGE closes it.
- R9: A PRECHARGE is always allowed and closes the addressed bank.
- R10: A refused command changes no state: open flags, stored rows and countdowns stay as they were.
- R11: A cycle count is the time divided by the clock period, rounded up to the next whole cycle. With a 4000 ps clock and the default times this gives tRCD 6, tRC 17 and tRRD 4 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is offered this cycle |
| cmd | input | 3 | Command code |
| cmd_bank | input | 2 | Bank address |
| cmd_row | input | 13 | Row address, used by ACTIVE |
| cmd_ok | output | 1 | The offered command may be issued now |
| proto_err | output | 1 | READ or WRITE offered to a closed bank |
| bank_open | output | 4 | Open flag per bank |
| open_row | output | 13 | Stored row of the bank on `cmd_bank` |

## Verification
The global spacing between any two activations and the per-bank cycle time can both hold back the same ACTIVE. The bench provokes this by opening one bank, precharging it at once, opening a second bank and then offering re-activation of the first bank on every following cycle. Each offer is judged against two elapsed-cycle counts that the bench keeps itself, and it must be refused until both windows have run out. The sweeps over bank pairs and delays also test each window on its own at its exact boundary cycle.

// File: rtl/bank_act_guard.sv
module bank_act_guard #(
  parameter int CLK_PS  = 7500,
  parameter int TRCD_PS = 22500,
  parameter int TRC_PS  = 65000,
  parameter int TRRD_PS = 15000,
  parameter int BANK_W  = 2,
  parameter int ROW_W   = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [ROW_W-1:0]  cmd_row,
  output logic              cmd_ok,
  output logic              proto_err,
  output logic [(1<<BANK_W)-1:0] bank_open,
  output logic [ROW_W-1:0]  open_row
);
  localparam int NB    = 1 << BANK_W;
  localparam int RCD_C = (TRCD_PS + CLK_PS - 1) / CLK_PS;
  localparam int RC_C  = (TRC_PS + CLK_PS - 1) / CLK_PS;
  localparam int RRD_C = (TRRD_PS + CLK_PS - 1) / CLK_PS;
  localparam int MAX_C = (RC_C > RCD_C) ? ((RC_C > RRD_C) ? RC_C : RRD_C)
                                        : ((RCD_C > RRD_C) ? RCD_C : RRD_C);
  localparam int CW    = $clog2(MAX_C + 2);
  localparam logic [CW-1:0] RCD_LD = CW'((RCD_C > 0) ? RCD_C - 1 : 0);
  localparam logic [CW-1:0] RC_LD  = CW'((RC_C > 0) ? RC_C - 1 : 0);
  localparam logic [CW-1:0] RRD_LD = CW'((RRD_C > 0) ? RRD_C - 1 : 0);
  localparam logic [CW-1:0] SAT    = CW'(MAX_C);

  logic [CW-1:0]    rcd_q [NB];
  logic [CW-1:0]    rc_q  [NB];
  logic [ROW_W-1:0] row_q [NB];
  logic             open_q[NB];
  logic [CW-1:0]    rrd_q;

  wire is_act = (cmd == 3'd1);
  wire is_acc = (cmd == 3'd2) || (cmd == 3'd3);
  wire is_pre = (cmd == 3'd4);
  wire b_open = open_q[cmd_bank];

  assign cmd_ok    = is_act ? (!b_open && rc_q[cmd_bank] == '0 && rrd_q == '0)
                   : is_acc ? (b_open && rcd_q[cmd_bank] == '0)
                   : 1'b1;
  assign proto_err = cmd_valid && is_acc && !b_open;
  assign open_row  = row_q[cmd_bank];

  wire take = cmd_valid && cmd_ok;

  always_ff @(posedge clk) begin
    if (!rst_n)                rrd_q <= '0;
    else if (take && is_act)   rrd_q <= RRD_LD;
    else if (rrd_q != '0)      rrd_q <= rrd_q - 1'b1;
  end

  for (genvar i = 0; i < NB; i++) begin : g_bank
    wire hit = take && (cmd_bank == BANK_W'(i));
    assign bank_open[i] = open_q[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rcd_q[i]  <= '0;
        rc_q[i]   <= '0;
        row_q[i]  <= '0;
        open_q[i] <= 1'b0;
      end else if (hit && is_act) begin
        rcd_q[i]  <= RCD_LD;
        rc_q[i]   <= RC_LD;
        row_q[i]  <= cmd_row;
        open_q[i] <= 1'b1;
      end else begin
        if (rcd_q[i] != '0) rcd_q[i] <= rcd_q[i] - 1'b1;
        if (rc_q[i]  != '0) rc_q[i]  <= rc_q[i]  - 1'b1;
        if (hit && is_pre)  open_q[i] <= 1'b0;
      end
    end
  end

  logic [CW-1:0] since_any;
  logic [CW-1:0] since_b[NB];

  always_ff @(posedge clk) begin
    if (!rst_n)                  since_any <= SAT;
    else if (take && is_act)     since_any <= CW'(1);
    else if (since_any != SAT)   since_any <= since_any + 1'b1;
  end

  for (genvar i = 0; i < NB; i++) begin : g_chk
    always_ff @(posedge clk) begin
      if (!rst_n)                                         since_b[i] <= SAT;
      else if (take && is_act && cmd_bank == BANK_W'(i))  since_b[i] <= CW'(1);
      else if (since_b[i] != SAT)                         since_b[i] <= since_b[i] + 1'b1;
    end
  end

  // R7
  rrd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && is_act) |-> (since_any >= CW'(RRD_C)));
  // R6
  rc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && is_act) |-> (since_b[cmd_bank] >= CW'(RC_C)));
  // R5
  rcd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && is_acc) |-> (since_b[cmd_bank] >= CW'(RCD_C)));
  // R3
  act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && is_act) |=> bank_open[$past(cmd_bank)]);
  // R9
  pre_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && is_pre) |=> !bank_open[$past(cmd_bank)]);
  // R4
  err_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> !cmd_ok);
  // R10
  refused_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ok) |=> $stable(bank_open));
endmodule

// File: tb/bank_act_guard_test.sv
module bank_act_guard_test;
  localparam int CLKP = 4000;
  localparam int E_RCD = (22500 + CLKP - 1) / CLKP;
  localparam int E_RC  = (65000 + CLKP - 1) / CLKP;
  localparam int E_RRD = (15000 + CLKP - 1) / CLKP;
  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3, PRE = 3'd4;

  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0;
  logic [2:0] cmd = '0;
  logic [1:0] cmd_bank = '0;
  logic [12:0] cmd_row = '0;
  logic cmd_ok, proto_err;
  logic [3:0] bank_open;
  logic [12:0] open_row;
  int ntests = 0, nfail = 0;

  always #2 clk = ~clk;

  bank_act_guard #(.CLK_PS(CLKP)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_ok(cmd_ok),
    .proto_err(proto_err), .bank_open(bank_open), .open_row(open_row));

  task automatic check(input int act, input int exp, input string tag);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic offer(input logic [2:0] c, input logic [1:0] b, input logic [12:0] r);
    @(negedge clk);
    cmd_valid = 1'b1; cmd = c; cmd_bank = b; cmd_row = r;
    #1;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) offer(NOP, 2'd0, 13'd0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cmd_valid = 1'b0; cmd = NOP;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    #1 check(bank_open, 0, "R1 bank_open after reset");
    // R4 access to closed bank
    offer(RD, 2'd0, 0);
    check(cmd_ok, 0, "R4 read closed ok");
    check(proto_err, 1, "R4 read closed err");
    offer(WR, 2'd3, 0);
    check(proto_err, 1, "R4 write closed err");
    // R10 refused access left state alone
    check(bank_open, 0, "R10 after refused access");
    // R2 nop and spare codes
    offer(NOP, 2'd1, 0);
    check(cmd_ok, 1, "R2 nop ok");
    offer(3'd6, 2'd1, 13'h55);
    check(cmd_ok, 1, "R2 spare code ok");
    offer(NOP, 2'd1, 0);
    check(bank_open, 0, "R2 spare code no effect");
    check(open_row, 0, "R2 spare code row");
    // R1 every bank activatable just after reset
    for (int b = 0; b < 4; b++) begin
      do_reset();
      offer(ACT, 2'(b), 13'(100 + b));
      check(cmd_ok, 1, "R1 first act ok");
      offer(NOP, 2'(b), 0);
      check(bank_open, 1 << b, "R3 bank_open after act");
      check(open_row, 100 + b, "R3 stored row");
    end

    // R5 / R11 tRCD boundary sweep
    for (int b = 0; b < 4; b++)
      for (int d = 0; d < E_RC + 2; d++) begin
        do_reset();
        offer(ACT, 2'(b), 13'h1AB);
        idle(d);
        offer((d % 2) ? WR : RD, 2'(b), 0);
        check(cmd_ok, (d + 1) >= E_RCD, "R5 access after act");
      end

    // R7 / R11 tRRD boundary sweep across bank pairs
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        if (a != b)
          for (int d = 0; d < E_RRD + 3; d++) begin
            do_reset();
            offer(ACT, 2'(a), 13'd7);
            idle(d);
            offer(ACT, 2'(b), 13'd9);
            check(cmd_ok, (d + 1) >= E_RRD, "R7 act other bank");
            offer(NOP, 2'(b), 0);
            // R10 refused act leaves bank closed
            check(bank_open[b], (d + 1) >= E_RRD, "R10 second bank open flag");
          end

    // R6 / R11 tRC after early precharge
    for (int b = 0; b < 4; b++)
      for (int d = 0; d < E_RC + 2; d++) begin
        do_reset();
        offer(ACT, 2'(b), 13'd1);
        offer(PRE, 2'(b), 0);
        check(cmd_ok, 1, "R9 precharge ok");
        idle(d);
        offer(ACT, 2'(b), 13'd2);
        check(cmd_ok, (d + 2) >= E_RC, "R6 reactivate same bank");
      end

    // R8 / R10 act to open bank refused, row kept
    do_reset();
    offer(ACT, 2'd2, 13'h0AA);
    idle(E_RC + 2);
    offer(ACT, 2'd2, 13'h155);
    check(cmd_ok, 0, "R8 act open bank");
    offer(NOP, 2'd2, 0);
    check(open_row, 13'h0AA, "R10 row kept after refused act");
    check(bank_open, 4'b0100, "R10 open kept after refused act");
    offer(PRE, 2'd2, 0);
    offer(NOP, 2'd2, 0);
    check(bank_open, 0, "R9 precharge closes");
    offer(RD, 2'd2, 0);
    check(proto_err, 1, "R4 read after precharge");
    offer(ACT, 2'd2, 13'h155);
    check(cmd_ok, 1, "R8 act after precharge");
    offer(NOP, 2'd2, 0);
    check(open_row, 13'h155, "R3 new row stored");

    // R6 with R7: both windows on one ACTIVE
    do_reset();
    offer(ACT, 2'd0, 13'd3);
    offer(PRE, 2'd0, 0);
    idle(E_RRD - 2);
    offer(ACT, 2'd1, 13'd4);
    check(cmd_ok, 1, "R7 act bank1 at boundary");
    for (int t = 1; t < E_RC; t++) begin
      int since0;
      since0 = E_RRD + t;
      offer(ACT, 2'd0, 13'd5);
      check(cmd_ok, (since0 >= E_RC) && (t >= E_RRD), "R6 combined window");
      if (cmd_ok) break;
    end

    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule